// File: doc/BRIEF.md
# Frame-Synchronous Byte Scrambler

This block scrambles a byte-wide transmit stream of a byte-interleaved frame built from `NUM_STS` STS-1 signals. It takes one byte per clock. The keystream comes from a length-127 sequence with generator 1 + x^6 + x^7. The generator steps eight times for each byte, and the first bit it produces becomes the MSB of the keystream byte.

The upstream framer supplies the row and column of each byte. From these the block finds two things. The first is the overhead bytes that carry framing, trace and growth information, which occupy row 1, columns 1 to 3·`NUM_STS`. These bytes pass through unscrambled. The second is the byte just after them, row 1 column 3·`NUM_STS`+1. At that byte the generator reloads to all ones, and it then runs on through the rest of the frame.

A software bit turns the XOR off. A stream-enable bit replaces the incoming data with all ones ahead of the scrambler. The result is registered, so every output byte appears one clock after its input byte.

Top module: `frame_scrambler`

## Requirements
- R1: While reset is asserted and after its release, `vld_o` is 0 and `data_o` is 0x00 until the first valid byte has been registered.
- R2: `vld_o` equals `byte_vld_i` delayed by exactly one clock, and every output byte appears one clock after its input byte.
- R3: On a valid byte at row 1, column 3·NUM_STS+1 (column 37 by default), the generator reloads to 1111111. With zero data and scrambling on, that byte and the three valid bytes after it come out as 0xFE, 0x04, 0x18, 0x51.
- R4: Valid bytes at row 1, columns 1 to 3·NUM_STS, leave the block unchanged and do not advance the generator.
- R5: With `scr_dis_i`=1, a valid non-overhead byte leaves the block unchanged, and the generator still advances by one byte.
- R6: With `stream_en_i`=0, the data entering the scrambler is 0xFF. Scrambled positions give 0xFF XOR keystream, and overhead positions give 0xFF.
- R7: A cycle with `byte_vld_i`=0 does not advance the generator and leaves `data_o` unchanged.
- R8: Rows 2 to 9 and the columns of row 1 after the reset byte are all scrambled, and the keystream runs on across row boundaries without reloading.
- R9: The byte keystream repeats every 127 bytes: the byte at index 127 after the reload is 0xFE again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld_i | input | 1 | Input byte is present this cycle |
| row_i | input | ROW_W | Frame row of the byte, 1 to 9 |
| col_i | input | COL_W | Interleaved column of the byte, starting at 1 |
| scr_dis_i | input | 1 | 1: pass the byte without XOR |
| stream_en_i | input | 1 | 0: force the pre-scrambler byte to 0xFF |
| data_i | input | 8 | Input byte |
| data_o | output | 8 | Scrambled byte |
| vld_o | output | 1 | Output byte is present |

## Verification
Zero data right after the reload shows the keystream bytes themselves and confirms the reload point and the bit order. All-ones data and the disabled stream show that the forcing is applied before the XOR and that the XOR still acts on it. Data fed across the overhead columns, and with scrambling switched off, separates bypass from keystream consumption. Idle gaps, a run across the row 2 boundary and a run of more than 127 bytes each show whether the generator advances only on scrambled bytes and wraps with the right period.

// File: rtl/frame_scrambler.sv
module frame_scrambler #(
  parameter int NUM_STS = 12,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             scr_dis_i,
  input  logic             stream_en_i,
  input  logic [7:0]       data_i,
  output logic [7:0]       data_o,
  output logic             vld_o
);
  localparam int OH_LAST = 3 * NUM_STS;
  localparam int RLD_COL = OH_LAST + 1;
  localparam logic [6:0] SEED = 7'h7F;

  // eight generator steps: {keystream byte, next state}
  function automatic logic [14:0] gen_byte(input logic [6:0] s);
    logic [6:0] t;
    logic [7:0] k;
    t = s;
    k = '0;
    for (int i = 0; i < 8; i++) begin
      k[7-i] = t[6];
      t = {t[5:0], t[6] ^ t[5]};
    end
    return {k, t};
  endfunction

  logic [6:0]  lfsr_q;
  logic [6:0]  cur_state;
  logic [14:0] gen;
  logic [7:0]  pre;
  logic        row1, oh_byte, rld_byte;

  assign row1      = (row_i == ROW_W'(1));
  assign oh_byte   = row1 && (col_i >= COL_W'(1)) && (col_i <= COL_W'(OH_LAST));
  assign rld_byte  = row1 && (col_i == COL_W'(RLD_COL));
  assign cur_state = rld_byte ? SEED : lfsr_q;
  assign gen       = gen_byte(cur_state);
  assign pre       = stream_en_i ? data_i : 8'hFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
      data_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= byte_vld_i;
      if (byte_vld_i) begin
        if (oh_byte) begin
          data_o <= pre;
        end else begin
          data_o <= scr_dis_i ? pre : (pre ^ gen[14:7]);
          lfsr_q <= gen[6:0];
        end
      end
    end
  end
endmodule

module frame_scrambler_chk #(
  parameter int NUM_STS = 12,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_vld_i,
  input logic [ROW_W-1:0] row_i,
  input logic [COL_W-1:0] col_i,
  input logic             scr_dis_i,
  input logic             stream_en_i,
  input logic [7:0]       data_i,
  input logic [7:0]       data_o,
  input logic             vld_o
);
  localparam int OH_LAST = 3 * NUM_STS;
  logic oh_in, rld_in;
  assign oh_in  = (row_i == ROW_W'(1)) && (col_i >= COL_W'(1)) && (col_i <= COL_W'(OH_LAST));
  assign rld_in = (row_i == ROW_W'(1)) && (col_i == COL_W'(OH_LAST + 1));

  p_vld_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o == $past(byte_vld_i));
  p_reload_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_i && rld_in && stream_en_i && !scr_dis_i |=> data_o == ($past(data_i) ^ 8'hFE));
  p_oh_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_i && oh_in && stream_en_i |=> data_o == $past(data_i));
  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_i && scr_dis_i && stream_en_i |=> data_o == $past(data_i));
  p_forced_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_i && !stream_en_i && (scr_dis_i || oh_in) |=> data_o == 8'hFF);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld_i |=> $stable(data_o));
endmodule

bind frame_scrambler frame_scrambler_chk #(.NUM_STS(NUM_STS), .ROW_W(ROW_W), .COL_W(COL_W)) u_chk (.*);

// File: tb/frame_scrambler_bench.sv
module frame_scrambler_bench;
  localparam int NUM_STS = 12;
  localparam int ROW_W = 4;
  localparam int COL_W = 11;
  localparam int RLD = 3 * NUM_STS + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_vld_i = 1'b0;
  logic [ROW_W-1:0] row_i = '0;
  logic [COL_W-1:0] col_i = '0;
  logic scr_dis_i = 1'b0;
  logic stream_en_i = 1'b1;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic vld_o;
  int vectors = 0;
  int miscompares = 0;
  bit seqb [127];

  always #2.5 clk = ~clk;

  frame_scrambler #(.NUM_STS(NUM_STS), .ROW_W(ROW_W), .COL_W(COL_W)) u_frame_scrambler (.*);

  // row-1 vectors from column 30 on: {col, data, stream_en, expected}
  localparam logic [27:0] VEC [6] = '{
    {11'd30, 8'hA5, 1'b1, 8'hA5},   // R4 overhead
    {11'd36, 8'h3C, 1'b1, 8'h3C},   // R4 last overhead column
    {11'd37, 8'h00, 1'b1, 8'hFE},   // R3 reload byte
    {11'd38, 8'h00, 1'b1, 8'h04},   // R3
    {11'd39, 8'hFF, 1'b1, 8'hE7},   // R3 0xFF ^ 0x18
    {11'd40, 8'h12, 1'b0, 8'hAE}    // R6 forced 0xFF ^ 0x51
  };

  function automatic logic [7:0] kbyte(input int k);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[7-j] = seqb[(8*k + j) % 127];
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic send(input int row, input int col, input logic [7:0] d, input logic dis,
                      input logic en, input logic [7:0] exp, input string tag);
    byte_vld_i = 1'b1;
    row_i = ROW_W'(row);
    col_i = COL_W'(col);
    data_i = d;
    scr_dis_i = dis;
    stream_en_i = en;
    @(negedge clk);
    check(tag, data_o, exp);
    check("R2 vld", {7'd0, vld_o}, 8'd1);
    byte_vld_i = 1'b0;
  endtask

  initial begin
    for (int n = 0; n < 127; n++) seqb[n] = (n < 7) ? 1'b1 : (seqb[n-6] ^ seqb[n-7]);
    repeat (3) @(negedge clk);
    check("R1 data", data_o, 8'h00);
    check("R1 vld", {7'd0, vld_o}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 data after release", data_o, 8'h00);
    check("R2 idle vld", {7'd0, vld_o}, 8'd0);

    foreach (VEC[i])
      send(1, int'(VEC[i][27:17]), VEC[i][16:9], 1'b0, VEC[i][8], VEC[i][7:0], "R3/R4/R6 table");

    send(1, 41, 8'h5A, 1'b1, 1'b1, 8'h5A, "R5 bypass");
    send(1, 42, 8'h00, 1'b0, 1'b1, kbyte(5), "R5 generator advanced");
    send(1, 43, 8'h00, 1'b1, 1'b0, 8'hFF, "R6 forced ones bypass");
    repeat (3) begin
      @(negedge clk);
      check("R7 idle hold", data_o, 8'hFF);
      check("R2 idle vld", {7'd0, vld_o}, 8'd0);
    end
    send(1, 44, 8'h00, 1'b0, 1'b1, kbyte(7), "R7 no advance in gap");
    send(1, 5, 8'h66, 1'b0, 1'b0, 8'hFF, "R4/R6 overhead forced");
    send(1, 45, 8'h00, 1'b0, 1'b1, kbyte(8), "R4 overhead no advance");

    send(1, RLD, 8'h00, 1'b0, 1'b1, 8'hFE, "R3 second reload");
    for (int k = 1; k <= 260; k++) begin
      if (k == 127) send(2, k, 8'h00, 1'b0, 1'b1, 8'hFE, "R9 period");
      else send(2 + (k-1)/1080, ((k-1) % 1080) + 1, 8'h00, 1'b0, 1'b1, kbyte(k), "R8 row 2 run");
    end
    @(negedge clk);
    check("R2 vld drop", {7'd0, vld_o}, 8'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule